// File: doc/BRIEF.md
# Light-Load Burst Mode Supervisor

This block decides when a switching power controller leaves ordinary valley-switched operation and drops into a low-power burst regime. It also runs the switching inside that regime and hands control back on a load step. Its inputs are already digitised. Four feedback comparator flags report the feedback voltage against the entry, burst-on, burst-off and exit levels. A 3-bit valley-count value comes from the frequency-reduction counter. A slow timebase tick times the blanking window. A peak-current comparator bit serves the reduced burst current limit.

Entry needs two things at once: feedback below the entry level, and the valley count at its maximum. Both must hold without a break for a blanking window measured in ticks. Inside burst mode, switching is enabled hysteretically. It turns on when feedback climbs above the burst-on level and turns off when feedback sinks below the burst-off level. While enabled, a fixed-period timer raises the gate at the start of each period. The gate falls after half a period, or earlier if the peak-current comparator trips. A separate, higher feedback level ends burst mode at once, and a one-cycle pulse tells the valley counter to reload to 1. While burst mode is active, a select output picks the reduced current-limit reference.

Top module: `burst_ctrl`

## Requirements
- R1: After synchronous reset, burst_active, sw_enable, gate, ilim_burst_sel and valley_reload are all 0.
- R2: With fb_below_entry = 1 and valley_cnt = 7 (all ones, 3 bits) held continuously, burst_active rises at the clock edge that samples the BLANK_TICKS-th tick pulse, and not before.
- R3: If fb_below_entry falls or valley_cnt differs from 7 for any cycle, the tick count restarts from zero. A full BLANK_TICKS further ticks are then needed for entry. Ticks while the conditions are not met have no effect.
- R4: ilim_burst_sel equals burst_active in every cycle.
- R5: In burst mode, sw_enable goes to 1 one edge after fb_above_on is sampled high with fb_below_off low. It goes to 0 one edge after fb_below_off is sampled high. Otherwise it holds. It is 0 whenever burst mode is not active, including right after entry.
- R6: From the cycle in which sw_enable becomes 1, gate repeats with a period of PERIOD_CLKS cycles. In each period it is high for the first PERIOD_CLKS/2 cycles and low for the rest.
- R7: If pk_trip is sampled high while gate is high, gate is low from the next cycle until the start of the next period, where it rises again.
- R8: When sw_enable falls, gate is low in that same cycle, even if a pulse was in progress. When sw_enable rises again, a fresh period starts with the gate high.
- R9: In burst mode, fb_above_exit sampled high makes burst_active and sw_enable 0 after that edge. valley_reload is 1 for exactly that one cycle.
- R10: Outside burst mode, fb_above_exit has no effect: valley_reload stays 0 and burst_active stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse for the entry blanking window |
| fb_below_entry | input | 1 | Feedback is below the burst entry level |
| fb_above_on | input | 1 | Feedback is above the burst switching-on level |
| fb_below_off | input | 1 | Feedback is below the burst switching-off level |
| fb_above_exit | input | 1 | Feedback is above the burst exit level |
| valley_cnt | input | VCNT_W | Current value of the valley (frequency-reduction) counter |
| pk_trip | input | 1 | Burst peak-current comparator output |
| burst_active | output | 1 | Burst mode is active |
| sw_enable | output | 1 | Switching is enabled within burst mode |
| gate | output | 1 | Fixed-frequency gate request in burst mode |
| ilim_burst_sel | output | 1 | Selects the reduced burst current limit |
| valley_reload | output | 1 | One-cycle pulse: reload the valley counter to 1 |

## Verification
All state changes are due exactly one edge after the input that causes them is sampled. This holds for entry on the last blanking tick, the on/off switching enable, exit with its reload pulse, and the gate cut after a peak-current trip. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check lands on the first cycle in which the new value is due. The exception is the gate falling with sw_enable: it is combinational from the enable register, so it is checked in the same sample that shows sw_enable low. Gate-shape checks count sampled cycles from the enable's rise and compare every cycle of two periods against position-in-period.

// File: rtl/burst_pkg.sv
// Shared types for the burst mode supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_pkg;

    // Operating regime of the supervisor.
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_BURST_HO = 2'b01,   // burst, switching held off
        MODE_BURST_SW = 2'b10    // burst, switching enabled
    } burst_mode_e;

endpackage

// File: rtl/burst_entry_qual.sv
// Entry qualifier: counts timebase ticks while both entry conditions hold.
// Raises entry_go for one cycle, on the tick that completes the window.
// Assumes: tick is a single-cycle pulse; the count is cleared while in burst.
module burst_entry_qual #(
    parameter int BLANK_TICKS = 24,
    parameter int VCNT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fb_below_entry,
    input  logic [VCNT_W-1:0] valley_cnt,
    input  logic              in_burst,
    output logic              entry_go
);
    localparam int BW = $clog2(BLANK_TICKS + 1);
    localparam logic [VCNT_W-1:0] VALLEY_MAX = {VCNT_W{1'b1}};
    localparam logic [BW-1:0] LAST = BW'(BLANK_TICKS - 1);

    logic          cond;
    logic [BW-1:0] blank_cnt;

    assign cond     = fb_below_entry && (valley_cnt == VALLEY_MAX) && !in_burst;
    assign entry_go = cond && tick && (blank_cnt == LAST);

    // Blanking window counter: restarts whenever a condition drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !cond) begin
            blank_cnt <= '0;
        end else if (tick && (blank_cnt != LAST)) begin
            blank_cnt <= blank_cnt + 1'b1;
        end
    end

    // R3
    qual_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (blank_cnt == '0));

endmodule

// File: rtl/burst_mode_fsm.sv
// Mode state machine: normal / burst held off / burst switching.
// Issues the valley reload pulse on exit.
// Assumes: exit has priority over the hysteresis flags; off wins over on.
module burst_mode_fsm
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic entry_go,
    input  logic fb_above_on,
    input  logic fb_below_off,
    input  logic fb_above_exit,
    output logic burst_active,
    output logic sw_enable,
    output logic valley_reload
);
    burst_mode_e mode_q, mode_d;

    // Next-mode selection.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL:   if (entry_go) mode_d = MODE_BURST_HO;
            MODE_BURST_HO: if (fb_above_exit) mode_d = MODE_NORMAL;
                           else if (fb_above_on && !fb_below_off) mode_d = MODE_BURST_SW;
            MODE_BURST_SW: if (fb_above_exit) mode_d = MODE_NORMAL;
                           else if (fb_below_off) mode_d = MODE_BURST_HO;
            default:       mode_d = MODE_NORMAL;
        endcase
    end

    // Mode register and the exit reload pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q        <= MODE_NORMAL;
            valley_reload <= 1'b0;
        end else begin
            mode_q        <= mode_d;
            valley_reload <= (mode_q != MODE_NORMAL) && (mode_d == MODE_NORMAL);
        end
    end

    assign burst_active = (mode_q != MODE_NORMAL);
    assign sw_enable    = (mode_q == MODE_BURST_SW);

    // R9
    exit_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && fb_above_exit) |=> (!burst_active && valley_reload));
    // R5
    sw_on_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_enable) |-> $past(fb_above_on && burst_active));
    // R9
    reload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valley_reload |=> !valley_reload);

endmodule

// File: rtl/burst_gate_timer.sv
// Fixed-period gate generator for burst switching with a half-period duty cap.
// A peak-current trip ends the current pulse early.
// Assumes: PERIOD_CLKS is even and at least 4; the counter restarts at each enable.
module burst_gate_timer #(
    parameter int PERIOD_CLKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_enable,
    input  logic pk_trip,
    output logic gate
);
    localparam int PW   = $clog2(PERIOD_CLKS);
    localparam int DUTY = PERIOD_CLKS / 2;
    localparam logic [PW-1:0] WRAP    = PW'(PERIOD_CLKS - 1);
    localparam logic [PW-1:0] DUTY_PW = PW'(DUTY);

    logic [PW-1:0] pcnt;
    logic          tripped;

    // Period position counter, held at zero while switching is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !sw_enable) begin
            pcnt <= '0;
        end else begin
            pcnt <= (pcnt == WRAP) ? '0 : pcnt + 1'b1;
        end
    end

    // Trip latch: set by the comparator during a pulse, cleared at period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !sw_enable) begin
            tripped <= 1'b0;
        end else if (pcnt == WRAP) begin
            tripped <= 1'b0;
        end else if (gate && pk_trip) begin
            tripped <= 1'b1;
        end
    end

    assign gate = sw_enable && (pcnt < DUTY_PW) && !tripped;

    // High-time run counter used only by the duty check below.
    logic [PW:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n) hi_run <= '0;
        else        hi_run <= gate ? hi_run + 1'b1 : '0;
    end

    // R6
    duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (hi_run < (PW+1)'(DUTY)));
    // R7
    trip_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && pk_trip && sw_enable && (pcnt != WRAP)) |=> !gate);

endmodule

// File: rtl/burst_ctrl.sv
// Top of the light-load burst mode supervisor.
// Ties the entry qualifier, mode FSM and gate timer together.
// Assumes: all feedback flags are synchronous to clk; tick is one cycle wide.
module burst_ctrl #(
    parameter int BLANK_TICKS = 24,
    parameter int PERIOD_CLKS = 5000,
    parameter int VCNT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fb_below_entry,
    input  logic              fb_above_on,
    input  logic              fb_below_off,
    input  logic              fb_above_exit,
    input  logic [VCNT_W-1:0] valley_cnt,
    input  logic              pk_trip,
    output logic              burst_active,
    output logic              sw_enable,
    output logic              gate,
    output logic              ilim_burst_sel,
    output logic              valley_reload
);
    localparam logic [VCNT_W-1:0] VALLEY_MAX = {VCNT_W{1'b1}};

    logic entry_go;

    burst_entry_qual #(.BLANK_TICKS(BLANK_TICKS), .VCNT_W(VCNT_W)) qual_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .fb_below_entry(fb_below_entry), .valley_cnt(valley_cnt),
        .in_burst(burst_active), .entry_go(entry_go)
    );

    burst_mode_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .entry_go(entry_go),
        .fb_above_on(fb_above_on), .fb_below_off(fb_below_off),
        .fb_above_exit(fb_above_exit), .burst_active(burst_active),
        .sw_enable(sw_enable), .valley_reload(valley_reload)
    );

    burst_gate_timer #(.PERIOD_CLKS(PERIOD_CLKS)) gate_i (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
        .pk_trip(pk_trip), .gate(gate)
    );

    assign ilim_burst_sel = burst_active;

    // R2
    entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |-> $past(fb_below_entry && tick && (valley_cnt == VALLEY_MAX)));
    // R6
    gate_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> burst_active);
    // R10
    reload_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valley_reload |-> ($past(burst_active) && !burst_active));

endmodule

// File: tb/burst_ctrl_tb_top.sv
// Directed bench for burst_ctrl: one task per scenario, each checking itself.
module burst_ctrl_tb_top;
    localparam int BT  = 24;
    localparam int PER = 20;
    localparam int DUT = PER / 2;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic fb_lo = 1'b0, fb_on = 1'b0, fb_off = 1'b0, fb_exit = 1'b0, pk = 1'b0;
    logic [2:0] vcnt = 3'd0;
    logic b_act, sw_en, gate, isel, vrel;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_ctrl #(.BLANK_TICKS(BT), .PERIOD_CLKS(PER), .VCNT_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fb_below_entry(fb_lo),
        .fb_above_on(fb_on), .fb_below_off(fb_off), .fb_above_exit(fb_exit),
        .valley_cnt(vcnt), .pk_trip(pk), .burst_active(b_act),
        .sw_enable(sw_en), .gate(gate), .ilim_burst_sel(isel),
        .valley_reload(vrel)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); tick = 1'b0; step();
        end
    endtask

    // Enter burst with a clean full window; leaves conditions released.
    task automatic enter_burst();
        fb_lo = 1'b1; vcnt = 3'd7;
        ticks(BT);
        fb_lo = 1'b0; vcnt = 3'd1;
    endtask

    task automatic exit_burst();
        fb_exit = 1'b1; step(); fb_exit = 1'b0; step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        chk("R1 burst_active", b_act, 1'b0);
        chk("R1 sw_enable", sw_en, 1'b0);
        chk("R1 gate", gate, 1'b0);
        chk("R1 ilim_sel", isel, 1'b0);
        chk("R1 valley_reload", vrel, 1'b0);
    endtask

    task automatic t_entry();
        fb_lo = 1'b1; vcnt = 3'd7;
        ticks(BT - 1);
        chk("R2 not before window", b_act, 1'b0);
        tick = 1'b1; step(); tick = 1'b0;
        chk("R2 entry on last tick", b_act, 1'b1);
        chk("R4 select follows", isel, 1'b1);
        chk("R5 off at entry", sw_en, 1'b0);
        fb_lo = 1'b0; vcnt = 3'd1;
        step();
    endtask

    task automatic t_exit();
        fb_exit = 1'b1; step(); fb_exit = 1'b0;
        chk("R9 burst cleared", b_act, 1'b0);
        chk("R9 reload pulse", vrel, 1'b1);
        chk("R4 select cleared", isel, 1'b0);
        step();
        chk("R9 reload one cycle", vrel, 1'b0);
    endtask

    task automatic t_restart();
        fb_lo = 1'b1; vcnt = 3'd7;
        ticks(10);
        vcnt = 3'd6; step(); vcnt = 3'd7;
        ticks(BT - 1);
        chk("R3 valley drop restarts", b_act, 1'b0);
        fb_lo = 1'b0; ticks(5); fb_lo = 1'b1;
        ticks(BT - 1);
        chk("R3 feedback drop restarts", b_act, 1'b0);
        ticks(1);
        chk("R3 full window after restart", b_act, 1'b1);
        fb_lo = 1'b0; vcnt = 3'd1;
        exit_burst();
    endtask

    task automatic t_exit_ignored();
        fb_exit = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R10 no reload outside burst", vrel, 1'b0);
        end
        fb_exit = 1'b0;
        vcnt = 3'd6; fb_lo = 1'b1; ticks(BT + 2);
        chk("R10 no entry below max count", b_act, 1'b0);
        fb_lo = 1'b0; vcnt = 3'd1;
    endtask

    task automatic t_hyst_gate();
        enter_burst();
        chk("R2 in burst", b_act, 1'b1);
        fb_on = 1'b1; step(); fb_on = 1'b0;
        chk("R5 enable on", sw_en, 1'b1);
        for (int k = 0; k < 2 * PER; k++) begin
            chk("R6 gate shape", gate, (k % PER) < DUT);
            chk("R5 enable holds", sw_en, 1'b1);
            step();
        end
        // now at position 0 of a period: pulse in progress, cut by trip
        step(); step(); step();
        pk = 1'b1; step(); pk = 1'b0;
        chk("R7 trip ends pulse", gate, 1'b0);
        for (int k = 4; k < PER; k++) begin
            if (k != 4) chk("R7 stays low", gate, 1'b0);
            step();
        end
        chk("R7 next period rises", gate, 1'b1);
        step(); step();
        fb_off = 1'b1; step(); fb_off = 1'b0;
        chk("R5 enable off", sw_en, 1'b0);
        chk("R8 pulse terminated", gate, 1'b0);
        step();
        fb_on = 1'b1; step(); fb_on = 1'b0;
        chk("R8 fresh period", gate, 1'b1);
        step();
        fb_exit = 1'b1; step(); fb_exit = 1'b0;
        chk("R9 enable cleared", sw_en, 1'b0);
        chk("R9 gate low", gate, 1'b0);
        chk("R9 reload", vrel, 1'b1);
        step();
    endtask

    initial begin
        t_reset();
        t_entry();
        t_exit();
        t_restart();
        t_exit_ignored();
        t_hyst_gate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule